// File: doc/BRIEF.md
# 40-bit Multiply-Accumulate Unit

This block is a pipelined signed multiply-accumulate engine built around one 40-bit accumulator. Each cycle it can accept one operation carrying two 32-bit operands, a 2-bit operation code and two half-select bits. The operation is one of four kinds. The first multiplies one chosen 16-bit half of each operand. The second multiplies the packed halves pairwise and adds both lane products. The third forms a full 32x32 signed product. The fourth loads the accumulator with a new value. Every product is sign-extended before it is added. The accumulator wraps modulo 2^40 and never saturates.

Operations pass through a four-stage datapath. Stage one registers the operands. Stage two forms the products. Stage three builds one 40-bit addend. Stage four updates the accumulator. A load travels through the same stages, so it always lands after every earlier operation. A small read controller returns the accumulator. It has three states. RD_IDLE waits for a request and moves to RD_WAIT when one arrives. RD_WAIT holds while any operation is still in the datapath. Once the datapath is empty it captures the accumulator and moves to RD_DONE. RD_DONE presents the captured value for one cycle and then returns to RD_IDLE.

Top module: `mac40_unit`

## Requirements
- R1: After reset the accumulator is zero and both `busy` and `rd_valid` are low.
- R2: Opcode 0 adds the 32-bit signed product of two 16-bit halves, sign-extended to 40 bits. `in_hi_a` picks `in_a[31:16]` when set and `in_a[15:0]` when clear. `in_hi_b` picks the half of `in_b` in the same way.
- R3: Opcode 1 multiplies `in_a[31:16]` by `in_b[31:16]` and `in_a[15:0]` by `in_b[15:0]`, both signed. It sign-extends each product to 40 bits and adds both to the accumulator in one operation.
- R4: Opcode 2 adds the low 40 bits of the 64-bit signed product of `in_a` and `in_b`.
- R5: All accumulation wraps modulo 2^40, with no saturation.
- R6: Opcode 3 loads the accumulator with `{in_b[7:0], in_a}`. The load takes effect after every earlier accepted operation, and later operations accumulate on top of the loaded value.
- R7: An operation can be accepted in every cycle. `busy` is high from the cycle after acceptance until the accumulator has absorbed the operation, which is four clock edges after acceptance counting the accepting edge. The accumulator does not change while `busy` is low.
- R8: A read request in RD_IDLE with nothing in flight raises `rd_valid` for exactly one cycle, two edges after the request edge. `rd_data` then holds the accumulator. A request outside RD_IDLE is ignored.
- R9: A read stalls while `busy` is high. The value returned includes every operation accepted at or before the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation accepted this cycle |
| in_op | input | 2 | 0 halves MAC, 1 packed MAC, 2 wide MAC, 3 load |
| in_a | input | 32 | Multiplier operand / load low word |
| in_b | input | 32 | Multiplicand operand / load high byte in [7:0] |
| in_hi_a | input | 1 | Opcode 0: take upper half of `in_a` |
| in_hi_b | input | 1 | Opcode 0: take upper half of `in_b` |
| rd_req | input | 1 | Request an accumulator read |
| rd_valid | output | 1 | `rd_data` holds the accumulator this cycle |
| rd_data | output | 40 | Accumulator value returned by a read |
| busy | output | 1 | Operations still in the datapath |

## Verification
Operands are built from a set of 16-bit values: zero, one, minus one, the largest positive value, the most negative value and a few mixed patterns. The bench pairs them across the halves of both operands. Sweeping all four half-select combinations over these pairs exposes swapped or misrouted halves. The pairs with the most negative value and with minus one expose missing sign extension. Packed and wide operations run on the same pairs, each on top of a freshly loaded non-zero base. This exposes a dropped lane and wrong truncation of the wide product. Separate sequences cover the rest:
- boundary loads that cross 2^39 and 2^40;
- back-to-back bursts with a load in the middle;
- reads issued right behind an operation, which check the stall length and the returned value.

// File: rtl/mac40_pkg.sv
package mac40_pkg;

    typedef enum logic [1:0] {
        OP_MAC_HALF = 2'd0,
        OP_MAC_PACK = 2'd1,
        OP_MAC_WIDE = 2'd2,
        OP_LOAD     = 2'd3
    } mac_op_e;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_WAIT = 2'd1,
        RD_DONE = 2'd2
    } rd_state_e;

endpackage

// File: rtl/mac40_mul.sv
module mac40_mul
    import mac40_pkg::*;
#(
    parameter int OPW  = 32,
    parameter int ACCW = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                v_in,
    input  mac_op_e             op_in,
    input  logic [OPW-1:0]      a_in,
    input  logic [OPW-1:0]      b_in,
    input  logic                hi_a,
    input  logic                hi_b,
    output logic                v_out,
    output mac_op_e             op_out,
    output logic [OPW-1:0]      lane0_out,
    output logic [OPW-1:0]      lane1_out,
    output logic [ACCW-1:0]     wide_out
);
    localparam int HW = OPW / 2;

    logic [HW-1:0]   sel_a, sel_b;
    logic [OPW-1:0]  sa, sb, la, lb, ua, ub;
    logic [OPW-1:0]  lane0_d, lane1_d;
    logic [ACCW-1:0] wa, wb, wide_d;

    always_comb begin
        sel_a   = hi_a ? a_in[OPW-1:HW] : a_in[HW-1:0];
        sel_b   = hi_b ? b_in[OPW-1:HW] : b_in[HW-1:0];
        sa      = {{HW{sel_a[HW-1]}}, sel_a};
        sb      = {{HW{sel_b[HW-1]}}, sel_b};
        la      = {{HW{a_in[HW-1]}}, a_in[HW-1:0]};
        lb      = {{HW{b_in[HW-1]}}, b_in[HW-1:0]};
        ua      = {{HW{a_in[OPW-1]}}, a_in[OPW-1:HW]};
        ub      = {{HW{b_in[OPW-1]}}, b_in[OPW-1:HW]};
        wa      = {{(ACCW-OPW){a_in[OPW-1]}}, a_in};
        wb      = {{(ACCW-OPW){b_in[OPW-1]}}, b_in};
        lane0_d = '0;
        lane1_d = '0;
        wide_d  = '0;
        unique case (op_in)
            OP_MAC_HALF: lane0_d = sa * sb;
            OP_MAC_PACK: begin
                lane0_d = la * lb;
                lane1_d = ua * ub;
            end
            OP_MAC_WIDE: wide_d = wa * wb;
            OP_LOAD:     wide_d = {b_in[ACCW-OPW-1:0], a_in};
            default:     wide_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_out     <= 1'b0;
            op_out    <= OP_MAC_HALF;
            lane0_out <= '0;
            lane1_out <= '0;
            wide_out  <= '0;
        end else begin
            v_out     <= v_in;
            op_out    <= op_in;
            lane0_out <= lane0_d;
            lane1_out <= lane1_d;
            wide_out  <= wide_d;
        end
    end
endmodule

// File: rtl/mac40_addend.sv
module mac40_addend
    import mac40_pkg::*;
#(
    parameter int OPW  = 32,
    parameter int ACCW = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            v_in,
    input  mac_op_e         op_in,
    input  logic [OPW-1:0]  lane0,
    input  logic [OPW-1:0]  lane1,
    input  logic [ACCW-1:0] wide,
    output logic            v_out,
    output logic            load_out,
    output logic [ACCW-1:0] addend_out
);
    localparam int EXT = ACCW - OPW;

    logic [ACCW-1:0] x0, x1, addend_d;

    always_comb begin
        x0 = {{EXT{lane0[OPW-1]}}, lane0};
        x1 = {{EXT{lane1[OPW-1]}}, lane1};
        unique case (op_in)
            OP_MAC_HALF: addend_d = x0;
            OP_MAC_PACK: addend_d = x0 + x1;
            OP_MAC_WIDE: addend_d = wide;
            OP_LOAD:     addend_d = wide;
            default:     addend_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_out      <= 1'b0;
            load_out   <= 1'b0;
            addend_out <= '0;
        end else begin
            v_out      <= v_in;
            load_out   <= (op_in == OP_LOAD);
            addend_out <= addend_d;
        end
    end
endmodule

// File: rtl/mac40_rdctl.sv
module mac40_rdctl
    import mac40_pkg::*;
#(
    parameter int ACCW = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_req,
    input  logic            busy,
    input  logic [ACCW-1:0] acc,
    output logic            rd_valid,
    output logic [ACCW-1:0] rd_data
);
    rd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (rd_req) state_d = RD_WAIT;
            RD_WAIT: if (!busy)  state_d = RD_DONE;
            RD_DONE: state_d = RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (state_q == RD_WAIT && !busy) begin
            rd_data <= acc;
        end
    end

    always_comb rd_valid = (state_q == RD_DONE);
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
    import mac40_pkg::*;
#(
    parameter int OPW  = 32,
    parameter int ACCW = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      in_op,
    input  logic [OPW-1:0]  in_a,
    input  logic [OPW-1:0]  in_b,
    input  logic            in_hi_a,
    input  logic            in_hi_b,
    input  logic            rd_req,
    output logic            rd_valid,
    output logic [ACCW-1:0] rd_data,
    output logic            busy
);
    logic            s1_v, s1_hi_a, s1_hi_b;
    mac_op_e         s1_op;
    logic [OPW-1:0]  s1_a, s1_b;

    logic            s2_v;
    mac_op_e         s2_op;
    logic [OPW-1:0]  s2_l0, s2_l1;
    logic [ACCW-1:0] s2_w;

    logic            s3_v, s3_load;
    logic [ACCW-1:0] s3_add;

    logic [ACCW-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_op   <= OP_MAC_HALF;
            s1_a    <= '0;
            s1_b    <= '0;
            s1_hi_a <= 1'b0;
            s1_hi_b <= 1'b0;
        end else begin
            s1_v    <= in_valid;
            s1_op   <= mac_op_e'(in_op);
            s1_a    <= in_a;
            s1_b    <= in_b;
            s1_hi_a <= in_hi_a;
            s1_hi_b <= in_hi_b;
        end
    end

    mac40_mul #(.OPW(OPW), .ACCW(ACCW)) u_mul (
        .clk(clk), .rst_n(rst_n),
        .v_in(s1_v), .op_in(s1_op), .a_in(s1_a), .b_in(s1_b),
        .hi_a(s1_hi_a), .hi_b(s1_hi_b),
        .v_out(s2_v), .op_out(s2_op),
        .lane0_out(s2_l0), .lane1_out(s2_l1), .wide_out(s2_w)
    );

    mac40_addend #(.OPW(OPW), .ACCW(ACCW)) u_add (
        .clk(clk), .rst_n(rst_n),
        .v_in(s2_v), .op_in(s2_op),
        .lane0(s2_l0), .lane1(s2_l1), .wide(s2_w),
        .v_out(s3_v), .load_out(s3_load), .addend_out(s3_add)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)     acc_q <= '0;
        else if (s3_v)  acc_q <= s3_load ? s3_add : acc_q + s3_add;
    end

    always_comb busy = s1_v | s2_v | s3_v;

    mac40_rdctl #(.ACCW(ACCW)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .busy(busy), .acc(acc_q),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );
endmodule

// File: rtl/mac40_checker.sv
module mac40_checker #(
    parameter int ACCW = 40
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            busy,
    input logic            rd_valid,
    input logic [ACCW-1:0] rd_data,
    input logic [ACCW-1:0] acc_q
);
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> busy);

    a_r7_acc_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(acc_q));

    a_r8_valid_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r8_data_matches_acc: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_data == acc_q);

    a_r9_no_return_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!busy));
endmodule

bind mac40_unit mac40_checker #(.ACCW(ACCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .acc_q(acc_q)
);

// File: tb/sim_mac40_unit.sv
`timescale 1ns/1ps
module sim_mac40_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'd0;
    logic [31:0] in_a = '0, in_b = '0;
    logic        in_hi_a = 1'b0, in_hi_b = 1'b0;
    logic        rd_req = 1'b0;
    logic        rd_valid;
    logic [39:0] rd_data;
    logic        busy;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [39:0] model = '0;
    int lat;

    always #2 clk = ~clk;

    mac40_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_hi_a(in_hi_a), .in_hi_b(in_hi_b),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy)
    );

    function automatic logic [39:0] contrib(input logic [1:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic ha, input logic hb);
        logic [15:0] x, y;
        longint p, q;
        x = ha ? a[31:16] : a[15:0];
        y = hb ? b[31:16] : b[15:0];
        case (op)
            2'd0: p = longint'($signed(x)) * longint'($signed(y));
            2'd1: begin
                p = longint'($signed(a[31:16])) * longint'($signed(b[31:16]));
                q = longint'($signed(a[15:0]))  * longint'($signed(b[15:0]));
                p = p + q;
            end
            default: p = longint'($signed(a)) * longint'($signed(b));
        endcase
        return p[39:0];
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    // caller stands just after a negedge
    task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic ha, input logic hb);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_hi_a = ha; in_hi_b = hb;
        if (op == 2'd3) model = {b[7:0], a};
        else            model = model + contrib(op, a, b, ha, hb);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic load(input logic [39:0] v);
        issue(2'd3, v[31:0], {24'h0, v[39:32]}, 1'b0, 1'b0);
    endtask

    task automatic read_acc(input string tag);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        lat = 1;
        while (!rd_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check(tag, {24'h0, rd_data}, {24'h0, model});
        @(negedge clk);
    endtask

    logic [15:0] vals [8];

    initial begin
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'hFFFF; vals[3] = 16'h7FFF;
        vals[4] = 16'h8000; vals[5] = 16'h1234; vals[6] = 16'hC35A; vals[7] = 16'h0100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy after reset", {63'h0, busy}, 64'h0);
        check("R1 rd_valid after reset", {63'h0, rd_valid}, 64'h0);
        read_acc("R1 acc zero after reset");
        // R8 idle read latency
        check("R8 idle read latency", lat, 2);

        // sweeps R2 R3 R4
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [31:0] a, b;
                logic [39:0] base;
                a = {vals[i], vals[(i+3)%8]};
                b = {vals[j], vals[(j+5)%8]};
                base = 40'h12_3456_789A ^ 40'(i * 977 + j * 31);
                for (int hs = 0; hs < 4; hs++) begin
                    load(base);
                    issue(2'd0, a, b, hs[1], hs[0]);
                    read_acc("R2 half-select product");
                end
                load(base);
                issue(2'd1, a, b, 1'b0, 1'b0);
                read_acc("R3 packed lane sum");
                load(base);
                issue(2'd2, a, b, 1'b0, 1'b0);
                read_acc("R4 wide product low bits");
            end
        end

        // R5 wrap
        load(40'h7F_FFFF_FFFF);
        issue(2'd0, 32'h1, 32'h1, 1'b0, 1'b0);
        read_acc("R5 carry into bit 39");
        check("R5 value past 2^39", {24'h0, rd_data}, 64'h80_0000_0000);
        load(40'hFF_FFFF_FFFF);
        issue(2'd0, 32'h1, 32'h1, 1'b0, 1'b0);
        read_acc("R5 wrap at 2^40");
        check("R5 wrapped to zero", {24'h0, rd_data}, 64'h0);
        load(40'h0);
        issue(2'd0, 32'hFFFF, 32'h1, 1'b0, 1'b0);
        read_acc("R5 negative wraps below zero");

        // R6 ordering: op, load, op back to back
        load(40'h0);
        issue(2'd2, 32'h0012_3456, 32'h0000_0100, 1'b0, 1'b0);
        issue(2'd3, 32'hDEAD_BEEF, 32'h0000_00A5, 1'b0, 1'b0);
        issue(2'd0, 32'h0003_0000, 32'h0000_0007, 1'b1, 1'b0);
        read_acc("R6 load ordered among ops");
        check("R6 load then add", {24'h0, rd_data}, 64'hA5_DEAD_BEEF + 64'd21);

        // R7 back-to-back burst and busy timing
        load(40'h0);
        read_acc("R6 load alone");
        for (int k = 0; k < 10; k++)
            issue(2'(k % 3), {vals[k%8], vals[(k+2)%8]}, {vals[(k+5)%8], vals[(k+1)%8]},
                  k[0], k[1]);
        check("R7 busy at end of burst", {63'h0, busy}, 64'h1);
        read_acc("R7 burst of 10 accumulated");
        issue(2'd0, 32'h2, 32'h3, 1'b0, 1'b0);
        check("R7 busy one edge after accept", {63'h0, busy}, 64'h1);
        @(negedge clk);
        @(negedge clk);
        check("R7 busy three edges after accept", {63'h0, busy}, 64'h1);
        @(negedge clk);
        check("R7 busy low after fourth edge", {63'h0, busy}, 64'h0);
        read_acc("R7 single op result");

        // R9 stall
        issue(2'd1, 32'h0005_FFFE, 32'h0003_0004, 1'b0, 1'b0);
        read_acc("R9 read right behind op");
        check("R9 stall length", lat, 4);
        issue(2'd0, 32'h4, 32'h5, 1'b0, 1'b0);
        rd_req = 1'b1;
        issue(2'd0, 32'h6, 32'h7, 1'b0, 1'b0);
        rd_req = 1'b0;
        lat = 1;
        while (!rd_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check("R9 read includes same-edge op", {24'h0, rd_data}, {24'h0, model});

        // R8 request outside idle ignored, single-cycle valid
        @(negedge clk);
        check("R8 valid lasts one cycle", {63'h0, rd_valid}, 64'h0);
        rd_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8 valid while request held", {63'h0, rd_valid}, 64'h1);
        rd_req = 1'b0;
        @(negedge clk);
        check("R8 held request not retriggered", {63'h0, rd_valid}, 64'h0);
        @(negedge clk);
        check("R8 no second return", {63'h0, rd_valid}, 64'h0);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired got=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule